// File: doc/BRIEF.md
# Swap-Step Electrode Pulse Sequencer

This block produces the timed electrode gate enables for one swap step of a wire built from stationary qubits. A single start strobe launches a fixed program. First comes a cascade of four shuttle gates, with exactly one gate on at a time. The first and third gates each hold for four one-clock sub-steps, and the second and fourth each hold for two. After the cascade ends, the block plays an exchange-gate pulse train. This train is a 256-clock subsequence, with the gate off for the first two clocks and on for the other 254. The subsequence repeats 24 times.

An inner counter times each subsequence and wraps from its top value back to zero. An outer counter advances on each wrap and stops after the 24th one. When the last count has been played, the block raises a one-cycle done pulse and falls idle. A global enable freezes the whole sequence in place. While enable is low, every counter and every output holds its value.

Top module: `swp_pulse_seq`

## Requirements
- R1: Synchronous reset, sampled on a rising edge, returns the block to idle: `s_gate`, `a_gate`, `busy` and `done` are all low in the next cycle, and a later start plays the whole program from its beginning.
- R2: A start strobe sampled while `en` is high and `busy` is low is accepted: in the next cycle `busy` is high and `s_gate` is 4'b0001.
- R3: Number the cycles after an accepted start from 1. `s_gate` then reads 4'b0001 in cycles 1–4, 4'b0010 in cycles 5–6, 4'b0100 in cycles 7–10 and 4'b1000 in cycles 11–12, and it is zero in every other cycle. At most one of its bits is high at any time.
- R4: The exchange train begins in cycle 13, straight after the last cascade sub-step. Each 256-cycle subsequence holds `a_gate` low for its first 2 cycles and high for its remaining 254.
- R5: Exactly 24 subsequences are played, so the last train cycle is cycle 6156. `done` is high in cycle 6157 only. `busy` is high in cycles 1–6156 and falls in cycle 6157.
- R6: A start strobe sampled while `busy` is high has no effect on any output.
- R7: While `en` is low, every counter and every output holds its value. On re-enable, the sequence continues from where it stopped, and the frozen cycles do not count toward its length.
- R8: A start sampled in the `done` cycle is accepted, because the block is already idle, and a new program follows at once.
- R9: A start strobe sampled while `en` is low is ignored.
- R10: `a_gate` and any `s_gate` bit are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global advance enable; low freezes the block |
| start | input | 1 | Launches one swap-step program when idle |
| s_gate | output | 4 | One-hot shuttle gate enables; bit 0 is the first gate |
| a_gate | output | 1 | Exchange gate enable |
| busy | output | 1 | High while a program is running |
| done | output | 1 | One-cycle pulse after the final train count |

## Verification
The bench compares every output in every cycle against an independent phase model. This lets it catch off-by-one faults at each boundary: a sub-step length of three instead of four, a train that starts one cycle late, an off window of one or three clocks, or 23 or 25 repetitions. Each of these would move a transition away from its expected cycle. The bench also freezes the sequence with `en` low, both in the cascade and across an inner-counter wrap. A design that kept counting would arrive at `done` early, and one that kept only some outputs stable would be caught by the per-cycle hold checks. Start strobes are fired in the middle of the train, while `en` is low, and in the `done` cycle itself. A design that restarted, or that refused a start in the cycle where it is already idle, would drift from the model.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int NUM_SGATES = 4;
  typedef logic [NUM_SGATES-1:0] sgate_t;
  localparam sgate_t SG_NONE  = '0;
  localparam sgate_t SG_FIRST = sgate_t'(1);
endpackage

// File: rtl/swp_counter.sv
module swp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ena,
  output logic [W-1:0] q
);
  // Clear has priority over count; the count wraps naturally at 2**W.
  always_ff @(posedge clk) begin
    if (clr)      q <= '0;
    else if (ena) q <= q + W'(1);
  end
endmodule

// File: rtl/swp_s_cascade.sv
module swp_s_cascade
  import swp_pkg::*;
#(
  parameter int N1 = 4,
  parameter int N2 = 2,
  parameter int N3 = 4,
  parameter int N4 = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   start,
  output sgate_t gate,
  output logic   last
);
  localparam int MAXN12 = (N1 > N2) ? N1 : N2;
  localparam int MAXN34 = (N3 > N4) ? N3 : N4;
  localparam int MAXN   = (MAXN12 > MAXN34) ? MAXN12 : MAXN34;
  localparam int SW     = (MAXN > 1) ? $clog2(MAXN) : 1;
  localparam int LENS [NUM_SGATES] = '{N1, N2, N3, N4};

  sgate_t        gate_q;
  logic [SW-1:0] sub_q;
  logic [SW-1:0] end_val [NUM_SGATES];
  logic [SW-1:0] end_sel;
  logic          at_end;
  logic          sub_clr;

  // Each gate contributes its final sub-step index when it is the active one.
  for (genvar i = 0; i < NUM_SGATES; i++) begin : g_len
    assign end_val[i] = gate_q[i] ? SW'(LENS[i] - 1) : '0;
  end

  always_comb begin
    end_sel = '0;
    for (int i = 0; i < NUM_SGATES; i++) end_sel = end_sel | end_val[i];
  end

  assign at_end  = (|gate_q) && (sub_q == end_sel);
  assign sub_clr = rst || (en && (start || at_end));
  assign last    = en && gate_q[NUM_SGATES-1] && at_end;

  swp_counter #(.W(SW)) u_sub (
    .clk (clk),
    .clr (sub_clr),
    .ena (en && (|gate_q)),
    .q   (sub_q)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_q <= SG_NONE;
    else if (en) begin
      if (start)       gate_q <= SG_FIRST;
      else if (at_end) gate_q <= gate_q << 1;
    end
  end

  assign gate = gate_q;

  assert_onehot_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_q));

  assert_gate_order_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !start && at_end && !gate_q[NUM_SGATES-1]) |=> (gate_q != SG_NONE && gate_q != SG_FIRST));

  assert_freeze_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(gate_q) && $stable(sub_q)));
endmodule

// File: rtl/swp_a_train.sv
module swp_a_train #(
  parameter int SUB_W = 8,
  parameter int REPS  = 24,
  parameter int REP_W = 5,
  parameter int A_OFF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start_train,
  output logic a_gate,
  output logic last,
  output logic done
);
  localparam logic [SUB_W-1:0] CNT_TOP  = '1;
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPS - 1);
  localparam logic [SUB_W-1:0] OFF_LIM  = SUB_W'(A_OFF);

  logic             active_q;
  logic             a_q;
  logic             done_q;
  logic [SUB_W-1:0] cnt_q;
  logic [REP_W-1:0] rep_q;
  logic             wrap;
  logic [SUB_W-1:0] nxt_cnt;
  logic             a_nxt;

  assign wrap    = en && active_q && (cnt_q == CNT_TOP);
  assign last    = wrap && (rep_q == REP_LAST);
  assign nxt_cnt = start_train ? '0 : cnt_q + SUB_W'(1);
  assign a_nxt   = (start_train || (active_q && !last)) && (nxt_cnt >= OFF_LIM);

  swp_counter #(.W(SUB_W)) u_duty (
    .clk (clk),
    .clr (rst || (en && start_train)),
    .ena (en && active_q),
    .q   (cnt_q)
  );

  swp_counter #(.W(REP_W)) u_reps (
    .clk (clk),
    .clr (rst || last),
    .ena (wrap),
    .q   (rep_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      a_q      <= 1'b0;
      done_q   <= 1'b0;
    end else if (en) begin
      a_q    <= a_nxt;
      done_q <= last;
      if (start_train) active_q <= 1'b1;
      else if (last)   active_q <= 1'b0;
    end
  end

  assign a_gate = a_q;
  assign done   = done_q;

  assert_rep_bound_R5: assert property (@(posedge clk) disable iff (rst)
    rep_q <= REP_LAST);

  assert_idle_counters_R1: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (cnt_q == '0 && rep_q == '0));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    (done_q && en) |=> !done_q);

  assert_off_window_R4: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q < OFF_LIM) |-> !a_q);

  assert_freeze_train_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(cnt_q) && $stable(rep_q) && $stable(a_q) && $stable(done_q)));
endmodule

// File: rtl/swp_pulse_seq.sv
module swp_pulse_seq
  import swp_pkg::*;
#(
  parameter int N1    = 4,
  parameter int N2    = 2,
  parameter int N3    = 4,
  parameter int N4    = 2,
  parameter int SUB_W = 8,
  parameter int REPS  = 24,
  parameter int REP_W = 5,
  parameter int A_OFF = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  start,
  output logic [NUM_SGATES-1:0] s_gate,
  output logic                  a_gate,
  output logic                  busy,
  output logic                  done
);
  logic   busy_q;
  logic   accept;
  logic   casc_last;
  logic   train_last;
  sgate_t gate_w;

  assign accept = en && start && !busy_q;

  swp_s_cascade #(.N1(N1), .N2(N2), .N3(N3), .N4(N4)) u_casc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .start (accept),
    .gate  (gate_w),
    .last  (casc_last)
  );

  swp_a_train #(.SUB_W(SUB_W), .REPS(REPS), .REP_W(REP_W), .A_OFF(A_OFF)) u_train (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .start_train (casc_last),
    .a_gate      (a_gate),
    .last        (train_last),
    .done        (done)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else if (en) begin
      if (accept)          busy_q <= 1'b1;
      else if (train_last) busy_q <= 1'b0;
    end
  end

  assign busy   = busy_q;
  assign s_gate = gate_w;

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(a_gate && (|s_gate)));

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && s_gate == SG_FIRST));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !train_last) |=> busy);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_swp_pulse_seq.sv
module tb_swp_pulse_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CASC_LEN   = 12;
  localparam int SUB_LEN    = 256;
  localparam int NREP       = 24;
  localparam int TRAIN_END  = CASC_LEN + NREP * SUB_LEN;
  localparam int DONE_PH    = TRAIN_END + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       start = 1'b0;
  logic [3:0] s_gate;
  logic       a_gate, busy, done;

  int total = 0;
  int bad = 0;
  int ph = 0;
  int cycles = 0;

  swp_pulse_seq dut (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .s_gate(s_gate), .a_gate(a_gate), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Phase model: 0 = idle, 1..TRAIN_END running, DONE_PH = done cycle (idle).
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) ph <= 0;
    else if (en) begin
      if (ph == 0 || ph == DONE_PH) ph <= start ? 1 : 0;
      else ph <= ph + 1;
    end
  end

  function automatic logic [3:0] exp_s(int p);
    if (p >= 1 && p <= 4)   return 4'b0001;
    if (p >= 5 && p <= 6)   return 4'b0010;
    if (p >= 7 && p <= 10)  return 4'b0100;
    if (p >= 11 && p <= 12) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic exp_a(int p);
    if (p <= CASC_LEN || p > TRAIN_END) return 1'b0;
    return ((p - CASC_LEN - 1) % SUB_LEN) >= 2;
  endfunction

  task automatic compare(string tag);
    logic [3:0] es;
    logic ea, eb, ed;
    es = exp_s(ph);
    ea = exp_a(ph);
    eb = (ph >= 1 && ph <= TRAIN_END);
    ed = (ph == DONE_PH);
    total++;
    if (s_gate !== es || a_gate !== ea || busy !== eb || done !== ed ||
        (a_gate && |s_gate)) begin
      bad++;
      if (s_gate !== es)
        $display("FAIL %s R3 phase=%0d s_gate actual=%b expected=%b", tag, ph, s_gate, es);
      if (a_gate !== ea)
        $display("FAIL %s R4 phase=%0d a_gate actual=%b expected=%b", tag, ph, a_gate, ea);
      if (busy !== eb)
        $display("FAIL %s R2 phase=%0d busy actual=%b expected=%b", tag, ph, busy, eb);
      if (done !== ed)
        $display("FAIL %s R5 phase=%0d done actual=%b expected=%b", tag, ph, done, ed);
      if (a_gate && |s_gate)
        $display("FAIL %s R10 phase=%0d a_gate=1 with s_gate=%b expected none", tag, ph, s_gate);
    end
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_until_idle(string tag);
    while (ph != 0 && ph != DONE_PH) tick(tag);
    tick(tag);
  endtask

  task automatic test_reset_state();
    rst = 1'b1; en = 1'b1; start = 1'b0;
    tick("R1 reset");
    tick("R1 reset");
    rst = 1'b0;
    tick("R1 idle");
  endtask

  task automatic test_full_run();
    start = 1'b1;
    tick("R2 start");
    start = 1'b0;
    run_until_idle("R3 R4 R5 full");
  endtask

  task automatic test_start_while_busy();
    start = 1'b1; tick("R6 launch"); start = 1'b0;
    for (int i = 0; i < 7; i++) tick("R6 casc");
    start = 1'b1; tick("R6 busy start in cascade"); start = 1'b0;
    for (int i = 0; i < 400; i++) tick("R6 train");
    start = 1'b1; tick("R6 busy start in train"); start = 1'b0;
    run_until_idle("R6 tail");
    tick("R6 after done");
  endtask

  task automatic freeze_window(string tag, int n);
    logic [3:0] hs;
    logic ha, hb, hd;
    hs = s_gate; ha = a_gate; hb = busy; hd = done;
    en = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(tag);
      total++;
      if (s_gate !== hs || a_gate !== ha || busy !== hb || done !== hd) begin
        bad++;
        $display("FAIL %s R7 held outputs actual=%b%b%b%b expected=%b%b%b%b",
                 tag, s_gate, a_gate, busy, done, hs, ha, hb, hd);
      end
    end
    en = 1'b1;
  endtask

  task automatic test_enable_freeze();
    start = 1'b1; tick("R7 launch"); start = 1'b0;
    for (int i = 0; i < 3; i++) tick("R7 casc");
    freeze_window("R7 cascade", 5);
    while (ph != CASC_LEN + SUB_LEN) tick("R7 run");
    freeze_window("R7 wrap", 6);
    tick("R7 after wrap");
    while (ph != TRAIN_END) tick("R7 run");
    freeze_window("R7 last count", 3);
    run_until_idle("R7 finish");
  endtask

  task automatic test_start_en_low();
    en = 1'b0; start = 1'b1;
    tick("R9 start en low");
    tick("R9 start en low");
    start = 1'b0; en = 1'b1;
    tick("R9 still idle");
    total++;
    if (busy !== 1'b0) begin
      bad++;
      $display("FAIL R9 busy actual=%b expected=0", busy);
    end
  endtask

  task automatic test_reset_midrun();
    start = 1'b1; tick("R1 launch"); start = 1'b0;
    for (int i = 0; i < 1000; i++) tick("R1 run");
    rst = 1'b1; tick("R1 midrun reset"); rst = 1'b0;
    total++;
    if (s_gate !== 4'b0 || a_gate !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R1 after reset actual=%b%b%b%b expected=0000", s_gate, a_gate, busy, done);
    end
    start = 1'b1; tick("R1 restart"); start = 1'b0;
    run_until_idle("R1 rerun");
  endtask

  task automatic test_back_to_back();
    start = 1'b1; tick("R8 first"); start = 1'b0;
    while (ph != TRAIN_END) tick("R8 first run");
    tick("R8 done cycle");
    start = 1'b1; tick("R8 start on done"); start = 1'b0;
    total++;
    if (busy !== 1'b1 || s_gate !== 4'b0001) begin
      bad++;
      $display("FAIL R8 restart busy/s_gate actual=%b/%b expected=1/0001", busy, s_gate);
    end
    run_until_idle("R8 second run");
  endtask

  initial begin
    test_reset_state();
    test_full_run();
    test_start_while_busy();
    test_enable_freeze();
    test_start_en_low();
    test_reset_midrun();
    test_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d cycles expected fewer", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule